// File: doc/BRIEF.md
# Open-Drain GPIO Pair with Maskable Alert

This block provides two general-purpose pins with open-drain drivers. Each pin has a drive bit and a mask bit. A drive bit of 1 releases the pin, so the pad can be read as an input. A drive bit of 0 pulls the pad low. No separate direction bit exists, so writing 1 to the drive bit is what makes a pin an input. A host writes the drive bits and the mask bits through two separate write strobes. Reads return the stored drive bits and the synchronized pad levels.

Each released pin feeds a two-flop synchronizer and then a falling-edge detector with a debounce window. A falling edge on an unmasked, released pin that stays low for the whole window sets a shared alert latch. The latch pulls an active-low, open-drain alert line until the host sends an alert-response acknowledge. Before a pin is used as an output, its mask bit should be set so that driving it does not raise the alert.

Top module: `gpio_od_alert`

## Requirements
- R1: After reset both drive bits read 1, neither pad is pulled low, the mask bits are 1 and the alert line is released.
- R2: `pad_pull_low[i]` equals the inverse of drive bit i. It changes on the clock edge that captures a write on `wr_drv_en`, with no other enable involved.
- R3: `rd_drv` returns the last value written with `wr_drv_en`. `rd_level[i]` shows the pad level two clock edges after the pad changes.
- R4: A channel whose mask bit is 1 never sets the alert latch. A mask bit of 0 lets the channel's events through.
- R5: Only a falling edge counts as an event, and only while the channel's drive bit is 1. A pin pulled low by its own driver raises nothing. A pad that is still low after an acknowledge does not set the alert again.
- R6: The synchronized pad must be seen low on FILT_LEN (default 4) consecutive edges. With the default settings, a pad that falls just after an edge asserts `alert_pull_low` right after the sixth edge. A low pulse of FILT_LEN-1 samples is ignored.
- R7: Once set, the alert stays asserted until a cycle with `alert_ack` high. That cycle clears it on the next edge.
- R8: If a new event and an acknowledge fall on the same edge, the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_drv_en | input | 1 | Write strobe for the drive bits |
| wr_msk_en | input | 1 | Write strobe for the mask bits |
| wr_bits | input | NCH | Write data, bit i for channel i |
| pad_in | input | NCH | Level sensed at each pad |
| pad_pull_low | output | NCH | Pad driver enable; 1 pulls the pad low |
| alert_ack | input | 1 | Alert-response acknowledge |
| alert_pull_low | output | 1 | Alert driver enable; 1 pulls the alert line low |
| rd_drv | output | NCH | Drive bits read back |
| rd_level | output | NCH | Synchronized pad levels |

## Verification
The alert path is tested with low pulses one sample shorter than the window and exactly as long as it, which checks the window length and the exact edge on which the alert rises. A pin pulled low by its own driver, a masked pin, and a pad left low across an acknowledge each isolate one gating term: the drive bit, the mask bit, or the need for an edge. An event that coincides with an acknowledge shows which side of the latch wins. Drive-bit writes and readback are checked against the pad level that the bench models with a pull-up.

// File: rtl/gpio_od_pkg.sv
package gpio_od_pkg;
    localparam int unsigned GPIO_NCH_DEF   = 2;
    localparam int unsigned GPIO_FILT_DEF  = 4;
    localparam int unsigned GPIO_SYNC_DEF  = 2;

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/gpio_od_sync.sv
module gpio_od_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_od_filter.sv
module gpio_od_filter
    import gpio_od_pkg::*;
#(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic armed,
    output logic fire
);
    localparam int unsigned CW = cnt_bits(FILT_LEN);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t st_d, st_q;
    logic fall;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        fall      = st_q.prev & ~lvl;
        fire      = 1'b0;
        if (!armed || lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == '0) begin
            st_d.cnt = fall ? CW'(1) : '0;
        end else if (st_q.cnt == LAST) begin
            fire     = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gpio_od_alert.sv
module gpio_od_alert
    import gpio_od_pkg::*;
#(
    parameter int unsigned NCH      = GPIO_NCH_DEF,
    parameter int unsigned FILT_LEN = GPIO_FILT_DEF,
    parameter int unsigned SYNC_LEN = GPIO_SYNC_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_drv_en,
    input  logic           wr_msk_en,
    input  logic [NCH-1:0] wr_bits,
    input  logic [NCH-1:0] pad_in,
    output logic [NCH-1:0] pad_pull_low,
    input  logic           alert_ack,
    output logic           alert_pull_low,
    output logic [NCH-1:0] rd_drv,
    output logic [NCH-1:0] rd_level
);
    typedef struct packed {
        logic [NCH-1:0] drv;
        logic [NCH-1:0] msk;
        logic           alert;
    } top_t;

    top_t           st_d, st_q;
    logic [NCH-1:0] lvl_s;
    logic [NCH-1:0] armed;
    logic [NCH-1:0] fire;
    logic [NCH-1:0] mask_cur;

    gpio_od_sync #(.W(NCH), .STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (lvl_s)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign armed[c] = st_q.drv[c] & ~st_q.msk[c];
        gpio_od_filter #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (lvl_s[c]),
            .armed(armed[c]),
            .fire (fire[c])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_drv_en) st_d.drv = wr_bits;
        if (wr_msk_en) st_d.msk = wr_bits;
        if (|fire)          st_d.alert = 1'b1;
        else if (alert_ack) st_d.alert = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{drv: '1, msk: '1, alert: 1'b0};
        else        st_q <= st_d;
    end

    assign pad_pull_low   = ~st_q.drv;
    assign alert_pull_low = st_q.alert;
    assign rd_drv         = st_q.drv;
    assign rd_level       = lvl_s;
    assign mask_cur       = st_q.msk;
endmodule

// File: rtl/gpio_od_alert_chk.sv
module gpio_od_alert_chk #(
    parameter int unsigned NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_drv_en,
    input logic [NCH-1:0] wr_bits,
    input logic [NCH-1:0] pad_pull_low,
    input logic           alert_ack,
    input logic           alert_pull_low,
    input logic [NCH-1:0] rd_level,
    input logic [NCH-1:0] mask_cur
);
    AST_WR_DRIVES_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drv_en |=> (pad_pull_low == ~$past(wr_bits))); // R2

    AST_ALERT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_pull_low && !alert_ack) |=> alert_pull_low); // R7

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_ack && (&rd_level)) |=> !alert_pull_low); // R7

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_pull_low && (&mask_cur)) |=> !alert_pull_low); // R4

    AST_SET_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_pull_low) |-> !(&$past(rd_level))); // R6
endmodule

bind gpio_od_alert gpio_od_alert_chk #(.NCH(NCH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_drv_en     (wr_drv_en),
    .wr_bits       (wr_bits),
    .pad_pull_low  (pad_pull_low),
    .alert_ack     (alert_ack),
    .alert_pull_low(alert_pull_low),
    .rd_level      (rd_level),
    .mask_cur      (mask_cur)
);

// File: tb/gpio_od_alert_bench.sv
`timescale 1ns/1ps
module gpio_od_alert_bench;
    localparam int NCH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_drv_en = 1'b0, wr_msk_en = 1'b0, alert_ack = 1'b0;
    logic [NCH-1:0] wr_bits = '0;
    logic [NCH-1:0] ext = '1;
    logic [NCH-1:0] pad_in, pad_pull_low, rd_drv, rd_level;
    logic alert_pull_low;

    always #4 clk = ~clk;

    assign pad_in = ext & ~pad_pull_low;

    gpio_od_alert u_gpio_od_alert (
        .clk(clk), .rst_n(rst_n), .wr_drv_en(wr_drv_en), .wr_msk_en(wr_msk_en),
        .wr_bits(wr_bits), .pad_in(pad_in), .pad_pull_low(pad_pull_low),
        .alert_ack(alert_ack), .alert_pull_low(alert_pull_low),
        .rd_drv(rd_drv), .rd_level(rd_level)
    );

    typedef enum logic [1:0] {K_ALERT, K_OE, K_DRV, K_LVL} kind_t;
    typedef struct {
        kind_t       kind;
        logic [1:0]  val;
        string       req;
    } item_t;

    item_t q[$];
    int n_run = 0, n_fail = 0;
    bit done = 0;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_item(input kind_t k, input logic [1:0] v, input string r);
        item_t it;
        it.kind = k; it.val = v; it.req = r;
        q.push_back(it);
    endtask

    task automatic wr_drv(input logic [1:0] v);
        wr_bits = v; wr_drv_en = 1'b1; tick(1); wr_drv_en = 1'b0;
    endtask

    task automatic wr_msk(input logic [1:0] v);
        wr_bits = v; wr_msk_en = 1'b1; tick(1); wr_msk_en = 1'b0;
    endtask

    task automatic ack();
        alert_ack = 1'b1; tick(1); alert_ack = 1'b0;
    endtask

    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [1:0] act;
            it = q.pop_front();
            case (it.kind)
                K_ALERT: act = {1'b0, alert_pull_low};
                K_OE:    act = pad_pull_low;
                K_DRV:   act = rd_drv;
                default: act = rd_level;
            endcase
            n_run++;
            if (act !== it.val) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%b expected=%b", it.req, it.kind, act, it.val);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        expect_item(K_DRV, 2'b11, "R1");
        expect_item(K_OE, 2'b00, "R1");
        expect_item(K_ALERT, 2'b00, "R1");
        expect_item(K_LVL, 2'b11, "R1");

        // R2/R3: drive channel 1 low
        wr_drv(2'b01);
        expect_item(K_OE, 2'b10, "R2");
        expect_item(K_DRV, 2'b01, "R3");
        tick(2);
        expect_item(K_LVL, 2'b01, "R3");

        // R5: unmask while ch1 driven low, no alert
        wr_msk(2'b00);
        tick(8);
        expect_item(K_ALERT, 2'b00, "R5");
        wr_drv(2'b11);
        expect_item(K_OE, 2'b00, "R2");
        tick(8);
        expect_item(K_ALERT, 2'b00, "R5");
        expect_item(K_LVL, 2'b11, "R3");

        // R6: short pulse of FILT_LEN-1 samples ignored
        ext[0] = 1'b0; tick(3); ext[0] = 1'b1;
        tick(6);
        expect_item(K_ALERT, 2'b00, "R6");

        // R6: full window, alert right after sixth edge
        ext[0] = 1'b0;
        tick(5);
        expect_item(K_ALERT, 2'b00, "R6");
        tick(1);
        expect_item(K_ALERT, 2'b01, "R6");
        ext[0] = 1'b1;

        // R7: holds until acknowledge
        tick(10);
        expect_item(K_ALERT, 2'b01, "R7");
        ack();
        expect_item(K_ALERT, 2'b00, "R7");

        // R4: masked channel 0 blocked, channel 1 passes
        wr_msk(2'b01);
        ext[0] = 1'b0; tick(10); ext[0] = 1'b1;
        expect_item(K_ALERT, 2'b00, "R4");
        tick(4);
        ext[1] = 1'b0;
        tick(6);
        expect_item(K_ALERT, 2'b01, "R4");

        // R5: pad still low after ack, no new alert
        ack();
        expect_item(K_ALERT, 2'b00, "R7");
        tick(10);
        expect_item(K_ALERT, 2'b00, "R5");
        ext[1] = 1'b1;
        tick(4);

        // R8: event and acknowledge on same edge
        wr_msk(2'b00);
        ext[0] = 1'b0;
        tick(5);
        alert_ack = 1'b1;
        tick(1);
        alert_ack = 1'b0;
        expect_item(K_ALERT, 2'b01, "R8");
        ext[0] = 1'b1;
        tick(3);
        ack();
        expect_item(K_ALERT, 2'b00, "R7");

        // R2/R3: drive channel 0 low, readback
        wr_drv(2'b10);
        expect_item(K_OE, 2'b01, "R2");
        expect_item(K_DRV, 2'b10, "R3");
        tick(2);
        expect_item(K_LVL, 2'b10, "R3");
        tick(8);
        expect_item(K_ALERT, 2'b00, "R5");

        tick(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule